// File: doc/BRIEF.md
# Transition Activity Monitor

This block reports whether one chosen data lane changed level in both directions during each period of a slow, free-running sampling clock. A small selector picks the lane to observe from a set of candidate lanes. A selector code that does not name a lane parks the monitor on a constant low level. The observed level and the sampling clock are both asynchronous to the fast system clock. Each passes through a multi-stage synchroniser and then through an edge detector.

Two sticky flags record whether a rising edge and a falling edge have been seen since the last report. When the synchronised sampling clock rises, the AND of the two flags is moved to the activity output and both flags are cleared. The output therefore describes the window that has just closed, one window late, and holds that value until the next rising sampling edge. A scanning controller can step the lane selector and read one result per window. The sampling clock is expected to be far slower than the system clock, well under a tenth of its rate.

Top module: `actmon_top`

## Requirements
- R1: While reset (active low, sampled on the system clock) is asserted, the activity output is 0. It stays 0 after release until the first rising sampling edge is processed.
- R2: A report is 1 when the observed level rose at least once and fell at least once between two consecutive rising sampling edges.
- R3: A window that holds only rising edges, or only falling edges, reports 0.
- R4: A window in which the observed level is constant (low or high) reports 0.
- R5: A rising edge of the sampling clock changes the activity output on the third system clock edge after it; the output is unchanged on the second. Between reports the output is held.
- R6: Each report clears both flags, so an edge in one window never combines with an edge of the other polarity in a later window.
- R7: A falling edge of the sampling clock does not change the activity output.
- R8: A selector value below the lane count observes that lane; any value at or above it observes a constant 0. A selector change that changes the observed level counts as an edge of that polarity.
- R9: The first report after reset release covers the edges seen since the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_in | input | NUM_LANES (8) | Candidate lanes, asynchronous to clk |
| lane_sel | input | SEL_W (4) | Index of the observed lane; values >= NUM_LANES select nothing |
| samp_clk | input | 1 | Slow sampling clock, asynchronous to clk |
| activity | output | 1 | Result of the most recently closed sampling window |

## Verification
The hardest situation to reach from the ports is a pair of opposite edges that falls across a window boundary. The monitor must then report 0 twice, rather than merging the edges into one window. The stimulus raises a lane in one window and lowers it in the next. It also produces edges only by moving the selector between lanes held at fixed, different levels. The bench samples the output on the second and the third system clock edge after each sampling edge, to pin the one-window latency exactly.

// File: rtl/actmon_pkg.sv
// Package: shared types and helpers for the transition activity monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package actmon_pkg;

    // One edge observation of a single-bit signal.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Selector width: enough for every lane plus room for "no lane" codes.
    function automatic int sel_width(input int lanes);
        return (lanes < 2) ? 1 : $clog2(lanes) + 1;
    endfunction

endpackage

// File: rtl/actmon_sync.sv
// Module: multi-bit, multi-stage level synchroniser.
// What it does: carries WIDTH independent asynchronous levels into the clk
// domain through STAGES flops each. Each bit is synchronised separately.
// Assumes: inputs are levels held for at least STAGES+1 clk cycles; all
// stages reset to 0.
module actmon_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    // Remaining stages form the settling chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/actmon_edge.sv
// Module: per-bit edge detector.
// What it does: keeps the previous level of each synchronised bit and flags a
// one-cycle rise or fall pulse when the level changes.
// Assumes: level_i is already in the clk domain; the history resets low, so a
// level that is high at reset release is seen as a rising edge.
module actmon_edge #(
    parameter int WIDTH = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [WIDTH-1:0]                      level_i,
    output actmon_pkg::edge_pair_t [WIDTH-1:0]    ev_o
);

    logic [WIDTH-1:0] prev_q;

    // Keep last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Compare current and previous level for each bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign ev_o[b].rise = level_i[b] & ~prev_q[b];
        assign ev_o[b].fall = ~level_i[b] & prev_q[b];
    end

endmodule

// File: rtl/actmon_window.sv
// Module: sticky edge flags and per-window report register.
// What it does: remembers whether a rise and a fall of the observed data have
// been seen since the last sampling tick. On a tick it reports their AND and
// restarts both flags from any edge arriving in that same cycle.
// Assumes: the sample and data edge pulses are single-cycle and in the clk
// domain.
module actmon_window (
    input  logic                   clk,
    input  logic                   rst_n,
    input  actmon_pkg::edge_pair_t data_ev,
    input  logic                   sample_rise,
    input  logic                   sample_fall,
    output logic                   activity_o
);

    logic rise_seen;
    logic fall_seen;

    // Sticky rising-edge flag, restarted by every sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           rise_seen <= 1'b0;
        else if (sample_rise) rise_seen <= data_ev.rise;
        else                  rise_seen <= rise_seen | data_ev.rise;
    end

    // Sticky falling-edge flag, restarted by every sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           fall_seen <= 1'b0;
        else if (sample_rise) fall_seen <= data_ev.fall;
        else                  fall_seen <= fall_seen | data_ev.fall;
    end

    // Report register: loaded only on a sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           activity_o <= 1'b0;
        else if (sample_rise) activity_o <= rise_seen & fall_seen;
    end

    // R1: reset forces a quiet report.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !activity_o);

    // R5: without a tick the report holds.
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_rise |=> $stable(activity_o));

    // R3: a missing rise forbids a positive report.
    a_r3_need_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_rise && !rise_seen) |=> !activity_o);

    // R3: a missing fall forbids a positive report.
    a_r3_need_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_rise && !fall_seen) |=> !activity_o);

    // R6: a tick without a fresh rise leaves the rise flag clear.
    a_r6_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_rise && !data_ev.rise) |=> !rise_seen);

    // R6: a tick without a fresh fall leaves the fall flag clear.
    a_r6_clear_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_rise && !data_ev.fall) |=> !fall_seen);

    // R7: a falling sampling edge leaves the report alone.
    a_r7_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        sample_fall |=> $stable(activity_o));

endmodule

// File: rtl/actmon_top.sv
// Module: transition activity monitor, top level.
// What it does: selects one lane, synchronises it together with the sampling
// clock, detects edges of both, and reports per sampling window whether the
// lane moved both up and down.
// Assumes: samp_clk is much slower than clk; lane levels and the selector are
// held for at least SYNC_STAGES+1 clk cycles between changes.
module actmon_top #(
    parameter int NUM_LANES   = 8,
    parameter int SEL_W       = actmon_pkg::sel_width(NUM_LANES),
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_in,
    input  logic [SEL_W-1:0]     lane_sel,
    input  logic                 samp_clk,
    output logic                 activity
);

    localparam int SIG_DATA = 0;
    localparam int SIG_SAMP = 1;
    localparam int SIG_N    = 2;

    logic                                observed;
    logic [SIG_N-1:0]                    raw_sig;
    logic [SIG_N-1:0]                    sync_sig;
    actmon_pkg::edge_pair_t [SIG_N-1:0]  sig_ev;

    // Lane selector: codes at or above NUM_LANES observe a constant low.
    always_comb begin
        observed = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_sel == SEL_W'(i)) observed = lane_in[i];
        end
    end

    assign raw_sig[SIG_DATA] = observed;
    assign raw_sig[SIG_SAMP] = samp_clk;

    actmon_sync #(
        .WIDTH  (SIG_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_sig),
        .sync_o  (sync_sig)
    );

    actmon_edge #(
        .WIDTH (SIG_N)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_sig),
        .ev_o    (sig_ev)
    );

    actmon_window u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_ev     (sig_ev[SIG_DATA]),
        .sample_rise (sig_ev[SIG_SAMP].rise),
        .sample_fall (sig_ev[SIG_SAMP].fall),
        .activity_o  (activity)
    );

endmodule

// File: tb/sim_actmon_top.sv
// Bench for actmon_top: directed corner windows plus seeded random windows,
// with the expected report computed from counted edges of the selected lane.
module sim_actmon_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lane_in = 8'h00;
    logic [3:0] lane_sel = 4'd0;
    logic       samp_clk = 1'b0;
    logic       activity;

    int  n_chk = 0;
    int  n_bad = 0;
    int  rc = 0;
    int  fc = 0;
    logic cur_obs = 1'b0;
    logic prev_exp = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    actmon_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_in  (lane_in),
        .lane_sel (lane_sel),
        .samp_clk (samp_clk),
        .activity (activity)
    );

    // Level seen by the monitor for a given lane set and selector (R8).
    function automatic logic obs_of(input logic [7:0] l, input logic [3:0] s);
        return (s < 4'd8) ? l[s[2:0]] : 1'b0;
    endfunction

    // Expected report from the edge counts of one window (R2, R3, R4).
    function automatic logic exp_of(input int r, input int f);
        return (r > 0) && (f > 0);
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: activity=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Apply one lane/selector setting and count the observed edges.
    task automatic drive(input logic [7:0] l, input logic [3:0] s);
        logic nv;
        nv = obs_of(l, s);
        if (nv && !cur_obs) rc++;
        if (!nv && cur_obs) fc++;
        cur_obs = nv;
        @(negedge clk);
        lane_in  = l;
        lane_sel = s;
        repeat (4) @(posedge clk);
    endtask

    // Close the window with a sampling edge and check latency and holding.
    task automatic close_window(input string req);
        logic e;
        e  = exp_of(rc, fc);
        rc = 0;
        fc = 0;
        @(negedge clk);
        samp_clk = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(activity, prev_exp, "R5 (not yet updated)");
        @(posedge clk);
        @(negedge clk);
        chk(activity, e, req);
        prev_exp = e;
        repeat (3) @(negedge clk);
        samp_clk = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(activity, e, "R7 (falling sample edge)");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(activity, 1'b0, "R1");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(activity, 1'b0, "R1 after release");

        // R9: first window after reset, lane 0 up and down.
        drive(8'h01, 4'd0);
        drive(8'h00, 4'd0);
        close_window("R9");

        // R4: constant low window.
        close_window("R4 const low");

        // R3: rise only.
        drive(8'h01, 4'd0);
        close_window("R3 rise only");

        // R4: constant high window.
        close_window("R4 const high");

        // R6: fall only, the earlier rise must not carry over.
        drive(8'h00, 4'd0);
        close_window("R6 split edges");

        // R3: fall only after a rise-only window.
        drive(8'h01, 4'd0);
        close_window("R3 rise only");
        drive(8'h00, 4'd0);
        close_window("R3 fall only");

        // R8: selector code with no lane ignores toggling lanes.
        drive(8'h00, 4'd9);
        drive(8'hFF, 4'd9);
        drive(8'h00, 4'd9);
        drive(8'hFF, 4'd15);
        drive(8'h00, 4'd15);
        close_window("R8 no lane");

        // R8: edges made only by moving the selector between static lanes.
        drive(8'h08, 4'd9);
        drive(8'h08, 4'd3);
        drive(8'h08, 4'd2);
        close_window("R8 selector edges");

        // R2: several full toggles.
        drive(8'h04, 4'd2);
        drive(8'h00, 4'd2);
        drive(8'h04, 4'd2);
        drive(8'h00, 4'd2);
        close_window("R2 toggles");

        // R2: seeded random windows.
        for (int w = 0; w < 40; w++) begin
            int steps;
            steps = int'($urandom % 5);
            for (int k = 0; k < steps; k++) begin
                logic [7:0] l;
                logic [3:0] s;
                l = 8'($urandom);
                s = 4'($urandom % 11);
                drive(l, s);
            end
            close_window("R2 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule